// File: doc/BRIEF.md
# Ball Motion and Collision Engine

This block owns the ball of a hardwired paddle game. It keeps the ball's horizontal and vertical position and advances it once per video field, only along diagonals. A horizontal direction bit and a vertical direction bit set the travel. Comparators against the walls and the two paddles flip those bits. All arithmetic and comparisons are integer and happen in a single clock cycle after the field strobe.

Four active-low mode pins set how play behaves:

- speed sets a horizontal step of one or two units per field;
- angle count, in four-angle mode, adds a steep vertical rate that depends on where the ball strikes the paddle;
- paddle size sets a tall or a short paddle;
- manual serve holds a parked ball until a serve pulse arrives, instead of waiting for a field-count timer.

When the ball crosses a goal line, the block reports which side it left by, puts the ball back at the centre and parks it. A raster-position input drives a ball-video flag for the picture generator. Scoring is done downstream, from the goal pulse.

Top module: `ball_motion_engine`

## Requirements
- R1: After reset the ball sits at (CENTER_X, CENTER_Y) and is parked, with the direction set to right (+x) and down (+y). All event pulses are low.
- R2: On a field strobe with the ball not parked, x moves by 2 when fast_n=0 and by 1 when fast_n=1, in the current horizontal direction. Position never changes on any other cycle.
- R3: On the same strobe, y moves by 1 in the current vertical direction. In four-angle mode (angle4_n=0), y moves by 2 while the steep flag is set.
- R4: After a step, the vertical direction turns to down when the ball was moving up and the new y is at or below TOP_WALL. It turns to up when the ball was moving down and the new y is at or above BOT_WALL-4. Either case gives a one-cycle wall_pulse.
- R5: The ball meets the paddle it is travelling toward when two conditions hold. The x condition is new x <= LEFT_PAD_X when moving left, or new x >= RIGHT_PAD_X-2 when moving right. The y condition is that the ball rows y..y+3 overlap the paddle rows pad..pad+h-1. A meeting reverses the horizontal direction and gives a one-cycle hit_pulse.
- R6: Paddle height h is 24 rows when bigpad_n=0 and 16 rows when bigpad_n=1.
- R7: On a paddle hit in four-angle mode, the steep flag is set in one case: the ball centre row (y+2) is below pad+h/4, or at or beyond pad+h-h/4. Otherwise the flag is cleared. In two-angle mode a hit always clears it, so the vertical step stays 1.
- R8: A goal occurs when a step takes x to <= LEFT_GOAL while moving left, or to >= RIGHT_GOAL while moving right. The block then pulses goal_pulse for one cycle, with goal_right=1 for the right line and 0 for the left. The ball returns to the centre, parks and clears steep. No hit or wall is reported for that step.
- R9: With manual_n=1, a parked ball is released on the SERVE_FIELDS-th field strobe after parking. In this mode serve_pulse has no effect.
- R10: With manual_n=0, the field timer does not release the ball. A serve_pulse while parked releases it.
- R11: ball_vid is 1 exactly when ball_x <= scan_x < ball_x+2 and ball_y <= scan_y < ball_y+4.
- R12: Collisions are tested on the stepped position of the same strobe. A direction change shows in the motion of the following field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_tick | input | 1 | One-cycle strobe per video field |
| serve_pulse | input | 1 | Manual serve request |
| manual_n | input | 1 | Active-low manual-serve mode |
| fast_n | input | 1 | Active-low two-unit horizontal step |
| angle4_n | input | 1 | Active-low four-angle mode |
| bigpad_n | input | 1 | Active-low tall paddle |
| lpad_y | input | YW | Left paddle top row |
| rpad_y | input | YW | Right paddle top row |
| scan_x | input | XW | Raster column |
| scan_y | input | YW | Raster row |
| ball_x | output | XW | Ball left column |
| ball_y | output | YW | Ball top row |
| ball_vid | output | 1 | Raster inside ball box |
| hit_pulse | output | 1 | Paddle hit event |
| wall_pulse | output | 1 | Wall bounce event |
| goal_pulse | output | 1 | Goal event |
| goal_right | output | 1 | With goal_pulse: ball left by the right line |

## Verification
The bench builds the block with a serve count of 3 fields instead of a full second of fields. This brings auto-serve release, serve-pulse rejection and many goal-and-serve cycles into a short run. The coordinates are kept at their defaults: walls at rows 16 and 200, goals at columns 8 and 120. Paddles that track the ball at chosen offsets therefore hit the centre band, the outer quarters and the rows that only the tall paddle covers. Combined with the fast and four-angle pins, this produces steep two-row steps and both wall bounces.

// File: rtl/ball_pkg.sv
package ball_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } hdir_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } vdir_e;

  typedef struct packed {
    logic hit;
    logic wall;
    logic goal;
    logic side;
  } ball_evt_t;

  localparam int BALL_W = 2;
  localparam int BALL_H = 4;

endpackage

// File: rtl/ball_serve.sv
module ball_serve #(
  parameter int SERVE_FIELDS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic field_tick,
  input  logic serve_pulse,
  input  logic manual_n,
  input  logic goal_now,
  output logic parked
);

  localparam int CW = $clog2(SERVE_FIELDS + 1);
  localparam logic [CW-1:0] LAST = CW'(SERVE_FIELDS - 1);

  logic [CW-1:0] wait_cnt;
  logic          timer_done;
  logic          manual_go;

  assign timer_done = manual_n & field_tick & (wait_cnt == LAST);
  assign manual_go  = ~manual_n & serve_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked   <= 1'b1;
      wait_cnt <= '0;
    end else if (goal_now) begin
      parked   <= 1'b1;
      wait_cnt <= '0;
    end else if (parked) begin
      if (manual_go || timer_done) begin
        parked   <= 1'b0;
        wait_cnt <= '0;
      end else if (manual_n && field_tick) begin
        wait_cnt <= wait_cnt + CW'(1);
      end
    end
  end

  AST_PARK_AFTER_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
    goal_now |=> parked); // R8
  AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !manual_n && !serve_pulse) |=> parked); // R10
  AST_AUTO_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && manual_n && !field_tick) |=> parked); // R9

endmodule

// File: rtl/ball_video.sv
module ball_video
  import ball_pkg::*;
#(
  parameter int XW = 7,
  parameter int YW = 8
) (
  input  logic [XW-1:0] ball_x,
  input  logic [YW-1:0] ball_y,
  input  logic [XW-1:0] scan_x,
  input  logic [YW-1:0] scan_y,
  output logic          ball_vid
);

  localparam int XE = XW + 1;
  localparam int YE = YW + 1;

  function automatic logic in_span_x(logic [XW-1:0] org, logic [XW-1:0] pos);
    logic [XE-1:0] lo;
    logic [XE-1:0] p;
    lo = {1'b0, org};
    p  = {1'b0, pos};
    return (p >= lo) && (p < lo + XE'(BALL_W));
  endfunction

  function automatic logic in_span_y(logic [YW-1:0] org, logic [YW-1:0] pos);
    logic [YE-1:0] lo;
    logic [YE-1:0] p;
    lo = {1'b0, org};
    p  = {1'b0, pos};
    return (p >= lo) && (p < lo + YE'(BALL_H));
  endfunction

  assign ball_vid = in_span_x(ball_x, scan_x) & in_span_y(ball_y, scan_y);

endmodule

// File: rtl/ball_kin.sv
module ball_kin
  import ball_pkg::*;
#(
  parameter int XW          = 7,
  parameter int YW          = 8,
  parameter int LEFT_GOAL   = 8,
  parameter int LEFT_PAD_X  = 12,
  parameter int RIGHT_PAD_X = 112,
  parameter int RIGHT_GOAL  = 120,
  parameter int TOP_WALL    = 16,
  parameter int BOT_WALL    = 200,
  parameter int CENTER_X    = 64,
  parameter int CENTER_Y    = 100,
  parameter int PAD_SMALL   = 16,
  parameter int PAD_BIG     = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           field_tick,
  input  logic           parked,
  input  logic           fast_n,
  input  logic           angle4_n,
  input  logic           bigpad_n,
  input  logic [YW-1:0]  lpad_y,
  input  logic [YW-1:0]  rpad_y,
  output logic [XW-1:0]  pos_x,
  output logic [YW-1:0]  pos_y,
  output ball_evt_t      evt_q,
  output logic           goal_now
);

  localparam int XE = XW + 1;
  localparam int YE = YW + 1;
  localparam logic [XE-1:0] LGOAL_L = XE'(LEFT_GOAL);
  localparam logic [XE-1:0] RGOAL_L = XE'(RIGHT_GOAL);
  localparam logic [XE-1:0] LCONT_L = XE'(LEFT_PAD_X);
  localparam logic [XE-1:0] RCONT_L = XE'(RIGHT_PAD_X - BALL_W);
  localparam logic [YE-1:0] TOP_L   = YE'(TOP_WALL);
  localparam logic [YE-1:0] BOT_L   = YE'(BOT_WALL - BALL_H);
  localparam logic [XW-1:0] HOME_X  = XW'(CENTER_X);
  localparam logic [YW-1:0] HOME_Y  = YW'(CENTER_Y);

  hdir_e dir_x;
  vdir_e dir_y;
  logic  steep_q;

  function automatic logic [XE-1:0] h_next(logic [XW-1:0] x, hdir_e d, logic fast);
    logic [XE-1:0] s;
    s = fast ? XE'(2) : XE'(1);
    return (d == DIR_RIGHT) ? {1'b0, x} + s : {1'b0, x} - s;
  endfunction

  function automatic logic [YE-1:0] v_next(logic [YW-1:0] y, vdir_e d, logic steep);
    logic [YE-1:0] s;
    s = steep ? YE'(2) : YE'(1);
    return (d == DIR_DOWN) ? {1'b0, y} + s : {1'b0, y} - s;
  endfunction

  function automatic logic [YE-1:0] pad_len(logic big);
    return big ? YE'(PAD_BIG) : YE'(PAD_SMALL);
  endfunction

  function automatic logic rows_meet(logic [YE-1:0] by, logic [YW-1:0] py, logic big);
    logic [YE-1:0] p;
    p = {1'b0, py};
    return (by + YE'(BALL_H) > p) && (by < p + pad_len(big));
  endfunction

  function automatic logic outer_band(logic [YE-1:0] by, logic [YW-1:0] py, logic big);
    logic [YE-1:0] p;
    logic [YE-1:0] c;
    logic [YE-1:0] h;
    logic [YE-1:0] q;
    p = {1'b0, py};
    c = by + YE'(BALL_H / 2);
    h = pad_len(big);
    q = h >> 2;
    return (c < p + q) || (c >= p + h - q);
  endfunction

  logic [XE-1:0] nx;
  logic [YE-1:0] ny;
  logic          move;
  logic          wall_top;
  logic          wall_bot;
  logic          contact_x;
  logic [YW-1:0] near_pad;
  logic          pad_hit;
  logic          hit_steep;

  always_comb begin
    nx        = h_next(pos_x, dir_x, ~fast_n);
    ny        = v_next(pos_y, dir_y, steep_q & ~angle4_n);
    move      = field_tick & ~parked;
    goal_now  = move & (((dir_x == DIR_LEFT)  && (nx <= LGOAL_L)) ||
                        ((dir_x == DIR_RIGHT) && (nx >= RGOAL_L)));
    wall_top  = move & ~goal_now & (dir_y == DIR_UP)   & (ny <= TOP_L);
    wall_bot  = move & ~goal_now & (dir_y == DIR_DOWN) & (ny >= BOT_L);
    contact_x = (dir_x == DIR_RIGHT) ? (nx >= RCONT_L) : (nx <= LCONT_L);
    near_pad  = (dir_x == DIR_RIGHT) ? rpad_y : lpad_y;
    pad_hit   = move & ~goal_now & contact_x & rows_meet(ny, near_pad, ~bigpad_n);
    hit_steep = ~angle4_n & outer_band(ny, near_pad, ~bigpad_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_x   <= HOME_X;
      pos_y   <= HOME_Y;
      dir_x   <= DIR_RIGHT;
      dir_y   <= DIR_DOWN;
      steep_q <= 1'b0;
      evt_q   <= '0;
    end else begin
      evt_q.hit  <= pad_hit;
      evt_q.wall <= wall_top | wall_bot;
      evt_q.goal <= goal_now;
      evt_q.side <= goal_now & (dir_x == DIR_RIGHT);
      if (goal_now) begin
        pos_x   <= HOME_X;
        pos_y   <= HOME_Y;
        steep_q <= 1'b0;
      end else if (move) begin
        pos_x <= nx[XW-1:0];
        pos_y <= ny[YW-1:0];
        if (wall_top) dir_y <= DIR_DOWN;
        if (wall_bot) dir_y <= DIR_UP;
        if (pad_hit) begin
          dir_x   <= (dir_x == DIR_RIGHT) ? DIR_LEFT : DIR_RIGHT;
          steep_q <= hit_steep;
        end
      end
    end
  end

  AST_HIT_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.hit |-> (dir_x != $past(dir_x))); // R5
  AST_WALL_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.wall |-> (dir_y != $past(dir_y))); // R4
  AST_GOAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.goal |-> (pos_x == HOME_X && pos_y == HOME_Y)); // R8
  AST_GOAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.goal |-> (!evt_q.hit && !evt_q.wall)); // R8
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pos_x) || !$stable(pos_y)) |-> $past(field_tick)); // R2
  AST_FLAT_TWO_ANGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q.hit && $past(angle4_n)) |-> !steep_q); // R7

endmodule

// File: rtl/ball_motion_engine.sv
module ball_motion_engine
  import ball_pkg::*;
#(
  parameter int XW           = 7,
  parameter int YW           = 8,
  parameter int LEFT_GOAL    = 8,
  parameter int LEFT_PAD_X   = 12,
  parameter int RIGHT_PAD_X  = 112,
  parameter int RIGHT_GOAL   = 120,
  parameter int TOP_WALL     = 16,
  parameter int BOT_WALL     = 200,
  parameter int CENTER_X     = 64,
  parameter int CENTER_Y     = 100,
  parameter int PAD_SMALL    = 16,
  parameter int PAD_BIG      = 24,
  parameter int SERVE_FIELDS = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_tick,
  input  logic          serve_pulse,
  input  logic          manual_n,
  input  logic          fast_n,
  input  logic          angle4_n,
  input  logic          bigpad_n,
  input  logic [YW-1:0] lpad_y,
  input  logic [YW-1:0] rpad_y,
  input  logic [XW-1:0] scan_x,
  input  logic [YW-1:0] scan_y,
  output logic [XW-1:0] ball_x,
  output logic [YW-1:0] ball_y,
  output logic          ball_vid,
  output logic          hit_pulse,
  output logic          wall_pulse,
  output logic          goal_pulse,
  output logic          goal_right
);

  logic      parked;
  logic      goal_now;
  ball_evt_t evt;

  ball_kin #(
    .XW(XW), .YW(YW),
    .LEFT_GOAL(LEFT_GOAL), .LEFT_PAD_X(LEFT_PAD_X),
    .RIGHT_PAD_X(RIGHT_PAD_X), .RIGHT_GOAL(RIGHT_GOAL),
    .TOP_WALL(TOP_WALL), .BOT_WALL(BOT_WALL),
    .CENTER_X(CENTER_X), .CENTER_Y(CENTER_Y),
    .PAD_SMALL(PAD_SMALL), .PAD_BIG(PAD_BIG)
  ) u_kin (
    .clk(clk), .rst_n(rst_n), .field_tick(field_tick), .parked(parked),
    .fast_n(fast_n), .angle4_n(angle4_n), .bigpad_n(bigpad_n),
    .lpad_y(lpad_y), .rpad_y(rpad_y),
    .pos_x(ball_x), .pos_y(ball_y), .evt_q(evt), .goal_now(goal_now)
  );

  ball_serve #(.SERVE_FIELDS(SERVE_FIELDS)) u_serve (
    .clk(clk), .rst_n(rst_n), .field_tick(field_tick),
    .serve_pulse(serve_pulse), .manual_n(manual_n),
    .goal_now(goal_now), .parked(parked)
  );

  ball_video #(.XW(XW), .YW(YW)) u_vid (
    .ball_x(ball_x), .ball_y(ball_y), .scan_x(scan_x), .scan_y(scan_y),
    .ball_vid(ball_vid)
  );

  assign hit_pulse  = evt.hit;
  assign wall_pulse = evt.wall;
  assign goal_pulse = evt.goal;
  assign goal_right = evt.side;

  AST_PARKED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && $past(parked)) |-> ($stable(ball_x) && $stable(ball_y))); // R9
  AST_SIDE_WITH_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
    goal_right |-> goal_pulse); // R8

endmodule

// File: tb/sim_ball_motion_engine.sv
`timescale 1ns/1ps
module sim_ball_motion_engine;
  localparam int XW = 7, YW = 8;
  localparam int LG = 8, LPX = 12, RPX = 112, RG = 120;
  localparam int TW = 16, BW = 200, CX = 64, CY = 100;
  localparam int PS = 16, PB = 24, SF = 3;
  localparam int FAR_PAD = 230;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_tick = 1'b0, serve_pulse = 1'b0;
  logic manual_n = 1'b1, fast_n = 1'b1, angle4_n = 1'b1, bigpad_n = 1'b1;
  logic [YW-1:0] lpad_y = YW'(FAR_PAD), rpad_y = YW'(FAR_PAD);
  logic [XW-1:0] scan_x = '0;
  logic [YW-1:0] scan_y = '0;
  logic [XW-1:0] ball_x;
  logic [YW-1:0] ball_y;
  logic ball_vid, hit_pulse, wall_pulse, goal_pulse, goal_right;

  always #2.5 clk = ~clk;

  ball_motion_engine #(
    .XW(XW), .YW(YW), .LEFT_GOAL(LG), .LEFT_PAD_X(LPX), .RIGHT_PAD_X(RPX),
    .RIGHT_GOAL(RG), .TOP_WALL(TW), .BOT_WALL(BW), .CENTER_X(CX), .CENTER_Y(CY),
    .PAD_SMALL(PS), .PAD_BIG(PB), .SERVE_FIELDS(SF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .field_tick(field_tick), .serve_pulse(serve_pulse),
    .manual_n(manual_n), .fast_n(fast_n), .angle4_n(angle4_n), .bigpad_n(bigpad_n),
    .lpad_y(lpad_y), .rpad_y(rpad_y), .scan_x(scan_x), .scan_y(scan_y),
    .ball_x(ball_x), .ball_y(ball_y), .ball_vid(ball_vid), .hit_pulse(hit_pulse),
    .wall_pulse(wall_pulse), .goal_pulse(goal_pulse), .goal_right(goal_right)
  );

  typedef struct packed {
    int x; int y; bit hit; bit wall; bit goal; bit side;
  } exp_t;

  exp_t sb[$];
  int total = 0, bad = 0;
  int hits_seen = 0, walls_seen = 0, goals_seen = 0, steep_seen = 0;
  int mx, my, mdx, mdy, msteep, mpark, mcnt;
  int off = 0;
  bit track = 1'b0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic model_step(output exp_t e);
    int hs, vs, nx, ny, pad, h, c, q;
    bit contact;
    e = '0;
    if (mpark != 0) begin
      if (manual_n) begin
        if (mcnt == SF - 1) begin mpark = 0; mcnt = 0; end
        else mcnt++;
      end
    end else begin
      hs = fast_n ? 1 : 2;
      vs = (!angle4_n && msteep != 0) ? 2 : 1;
      nx = (mdx != 0) ? mx + hs : mx - hs;
      ny = (mdy != 0) ? my + vs : my - vs;
      if ((mdx == 0 && nx <= LG) || (mdx != 0 && nx >= RG)) begin
        e.goal = 1'b1; e.side = (mdx != 0);
        mx = CX; my = CY; mpark = 1; mcnt = 0; msteep = 0;
      end else begin
        mx = nx; my = ny;
        if (mdy == 0 && ny <= TW) begin mdy = 1; e.wall = 1'b1; end
        else if (mdy != 0 && ny >= BW - 4) begin mdy = 0; e.wall = 1'b1; end
        pad = (mdx != 0) ? int'(rpad_y) : int'(lpad_y);
        h = bigpad_n ? PS : PB;
        contact = (mdx != 0) ? (nx >= RPX - 2) : (nx <= LPX);
        if (contact && ny + 4 > pad && ny < pad + h) begin
          e.hit = 1'b1;
          mdx = (mdx != 0) ? 0 : 1;
          c = ny + 2; q = h / 4;
          msteep = (!angle4_n && (c < pad + q || c >= pad + h - q)) ? 1 : 0;
        end
      end
    end
    e.x = mx; e.y = my;
  endtask

  task automatic set_pads();
    int p;
    p = track ? my - off : FAR_PAD;
    if (p < 0) p = 0;
    if (p > 255) p = 255;
    lpad_y = YW'(p);
    rpad_y = YW'(p);
  endtask

  task automatic tick();
    exp_t e;
    @(negedge clk);
    set_pads();
    field_tick = 1'b1;
    model_step(e);
    sb.push_back(e);
    @(negedge clk);
    field_tick = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic serve();
    @(negedge clk);
    serve_pulse = 1'b1;
    if (!manual_n && mpark != 0) begin mpark = 0; mcnt = 0; end
    @(negedge clk);
    serve_pulse = 1'b0;
  endtask

  task automatic vid_chk(int dx, int dy, bit expv, string what);
    @(negedge clk);
    scan_x = XW'(int'(ball_x) + dx);
    scan_y = YW'(int'(ball_y) + dy);
    #1;
    chk(ball_vid == expv, "R11", what, int'(ball_vid), int'(expv));
  endtask

  task automatic clear_counts();
    hits_seen = 0; walls_seen = 0; goals_seen = 0; steep_seen = 0;
  endtask

  // scoreboard monitor: one expected item per field strobe
  initial begin
    exp_t e;
    int prev_y, d;
    prev_y = CY;
    forever begin
      @(posedge clk);
      if (field_tick) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "scoreboard empty", 0, 1);
        end else begin
          e = sb.pop_front();
          chk(int'(ball_x) == e.x, "R2", "ball_x", int'(ball_x), e.x);
          chk(int'(ball_y) == e.y, "R3", "ball_y", int'(ball_y), e.y);
          chk(hit_pulse == e.hit, "R5 R12", "hit_pulse", int'(hit_pulse), int'(e.hit));
          chk(wall_pulse == e.wall, "R4", "wall_pulse", int'(wall_pulse), int'(e.wall));
          chk(goal_pulse == e.goal, "R8", "goal_pulse", int'(goal_pulse), int'(e.goal));
          chk(goal_right == e.side, "R8", "goal_right", int'(goal_right), int'(e.side));
          d = int'(ball_y) - prev_y;
          if (!goal_pulse && (d == 2 || d == -2)) steep_seen++;
          prev_y = int'(ball_y);
          hits_seen  += int'(hit_pulse);
          walls_seen += int'(wall_pulse);
          goals_seen += int'(goal_pulse);
          if (e.hit || e.wall || e.goal) begin
            @(negedge clk);
            chk(!hit_pulse && !wall_pulse && !goal_pulse, "R5",
                "event pulse longer than one cycle", 1, 0);
          end
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mx = CX; my = CY; mdx = 1; mdy = 1; msteep = 0; mpark = 1; mcnt = 0;
    @(negedge clk);
    // R1 reset state
    chk(int'(ball_x) == CX, "R1", "reset ball_x", int'(ball_x), CX);
    chk(int'(ball_y) == CY, "R1", "reset ball_y", int'(ball_y), CY);
    chk(!hit_pulse && !wall_pulse && !goal_pulse, "R1", "reset pulses", 1, 0);
    // R11 box corners
    vid_chk(0, 0, 1'b1, "top-left inside");
    vid_chk(1, 3, 1'b1, "bottom-right inside");
    vid_chk(2, 0, 1'b0, "right of box");
    vid_chk(0, 4, 1'b0, "below box");
    vid_chk(-1, 1, 1'b0, "left of box");
    vid_chk(1, -1, 1'b0, "above box");

    // R9 auto serve, serve_pulse ignored
    tick();
    serve();
    tick();
    @(negedge clk);
    chk(int'(ball_x) == CX, "R9", "still parked after serve in auto mode", int'(ball_x), CX);
    tick();
    tick();
    @(negedge clk);
    chk(int'(ball_x) == CX + 1, "R2", "first slow step", int'(ball_x), CX + 1);
    chk(int'(ball_y) == CY + 1, "R3", "first vertical step", int'(ball_y), CY + 1);

    // far paddles: ball runs into the right goal
    clear_counts();
    run(60);
    chk(goals_seen >= 1, "R8", "goal with paddles away", goals_seen, 1);

    // small paddle tracking at centre: rallies and wall bounces
    track = 1'b1; off = 6;
    clear_counts();
    run(420);
    chk(hits_seen > 0, "R5", "rally hits", hits_seen, 1);
    chk(walls_seen > 0, "R4", "wall bounces", walls_seen, 1);
    chk(steep_seen == 0, "R7", "no steep steps in two-angle mode", steep_seen, 0);

    // rows 16..23 below paddle top: only the tall paddle reaches
    off = 18;
    clear_counts();
    run(150);
    chk(hits_seen == 0, "R6", "short paddle misses offset 18", hits_seen, 0);
    bigpad_n = 1'b0;
    clear_counts();
    run(150);
    chk(hits_seen > 0, "R6", "tall paddle hits offset 18", hits_seen, 1);

    // four-angle, fast, outer-quarter hits give steep travel
    angle4_n = 1'b0; fast_n = 1'b0; off = 0;
    clear_counts();
    run(250);
    chk(steep_seen > 0, "R7", "steep steps after outer hits", steep_seen, 1);
    off = 10;
    run(150);

    // manual serve: timer disabled, pulse releases
    manual_n = 1'b0; track = 1'b0;
    clear_counts();
    run(80);
    chk(goals_seen >= 1, "R8", "goal before manual serve", goals_seen, 1);
    run(10);
    @(negedge clk);
    chk(int'(ball_x) == CX, "R10", "parked ball waits for serve", int'(ball_x), CX);
    serve();
    tick();
    @(negedge clk);
    chk(int'(ball_x) != CX, "R10", "ball moves after serve", int'(ball_x), mx);
    run(20);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule